// File: doc/BRIEF.md
# Asynchronous Serial Receive Engine with Error-Gated Delivery

This block turns a serial receive line into bytes. It uses a baud tick at sixteen times the bit rate. The line idles high. A frame is one low start bit, eight data bits sent least significant bit first, an optional parity bit and one stop bit. The start bit is confirmed at its middle sample. Each later bit is sampled once per bit period, at the middle of the bit.

When the stop bit has been sampled, the frame is delivered to one of two places, chosen by a mode input:

- **Single mode:** the byte goes into a holding register. An unread flag tracks whether that byte has been read.
- **FIFO mode:** a ten-bit word goes to a downstream FIFO write port. The word holds the byte plus its parity and framing error bits.

Frames that have a parity error or a framing error are still received up to the stop position and still delivered. Such a frame raises the error pulse in place of the end pulse. Three status bits (parity, framing, overrun) stay set until they are cleared. Dropping the receive enable aborts any frame in progress without a trace: no pulse is raised and the status bits are cleared.

Top module: `uart_rx_gate`

## Requirements
- R1: In single mode, a frame without errors, completed with the holding register not unread, copies the byte into `hold_data` and pulses `rx_end` for one cycle in that same cycle. Data bits arrive least significant bit first.
- R2: In single mode, a frame that completes while the previous byte is unread and `hold_rd` is low is an overrun. `hold_data` is left unchanged, only `rx_err` pulses, and `st_ovr` is set.
- R3: A frame with a parity or framing error is received through its stop bit and then delivered. `rx_err` pulses in place of `rx_end`, and `st_pe` or `st_fe` is set to match the error. The two pulses are never high together.
- R4: Driving `rx_en` low while a frame is in progress stops it at once. `hold_data` is unchanged, no pulse follows, and `st_pe`, `st_fe` and `st_ovr` read 0 from the next cycle on.
- R5: While `rx_en` is 0, no frame is received and neither `rx_end` nor `rx_err` pulses.
- R6: A start bit that reads high at its middle sample (the eighth tick after the falling edge) is rejected. Nothing is delivered.
- R7: `par_cfg` selects the parity mode:
  - 00 or 11: no parity bit is sent.
  - 01: even parity, where the data bits and the parity bit together hold an even number of ones.
  - 10: odd parity, where the same count is odd.
- R8: A one-cycle `hold_rd` pulse clears the unread flag, so the next frame in single mode is copied normally.
- R9: In FIFO mode, each completed frame pulses `fifo_wr` once with `fifo_wdata` = {framing error in bit 9, parity error in bit 8, data in bits 7:0}. `rx_end` or `rx_err` pulses in the same cycle, and `hold_data` is not touched.
- R10: In FIFO mode with `fifo_full` high at completion, there is no write. `rx_err` pulses and `st_ovr` is set.
- R11: A stop bit sampled as 0 is a framing error.
- R12: After reset, `hold_data` is 0 and every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | Sampling tick at 16x the bit rate |
| rx | input | 1 | Serial receive line, idles high |
| rx_en | input | 1 | Receive enable; 0 aborts and clears status |
| fifo_mode | input | 1 | 0 = holding register, 1 = FIFO port |
| par_cfg | input | 2 | Parity mode: 01 even, 10 odd, others none |
| hold_rd | input | 1 | Read strobe for the holding register |
| fifo_full | input | 1 | Downstream FIFO cannot accept a word |
| hold_data | output | 8 | Holding register |
| fifo_wr | output | 1 | FIFO write strobe |
| fifo_wdata | output | 10 | FIFO word {fe, pe, data} |
| rx_end | output | 1 | Clean reception pulse |
| rx_err | output | 1 | Error reception pulse |
| st_pe | output | 1 | Sticky parity error |
| st_fe | output | 1 | Sticky framing error |
| st_ovr | output | 1 | Sticky overrun |

## Verification
The bit timing can drift, for example through a wrong tick count or a misplaced sample point. That shows up at the end of the very next frame as a rotated byte, a false parity error or a false framing error. A wrong unread flag shows one frame later, as a missed overrun or a spurious one, visible in which pulse fires and in whether `hold_data` moves. A bad abort path shows up as status bits that are still set, or a stray pulse, within the cycles right after `rx_en` falls.

// File: rtl/uart_rx_gate.sv
module uart_rx_gate #(
  parameter int OVS = 16,
  parameter int DW  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          baud_tick,
  input  logic          rx,
  input  logic          rx_en,
  input  logic          fifo_mode,
  input  logic [1:0]    par_cfg,
  input  logic          hold_rd,
  input  logic          fifo_full,
  output logic [DW-1:0] hold_data,
  output logic          fifo_wr,
  output logic [DW+1:0] fifo_wdata,
  output logic          rx_end,
  output logic          rx_err,
  output logic          st_pe,
  output logic          st_fe,
  output logic          st_ovr
);
  localparam int CW = $clog2(OVS);
  localparam int BW = $clog2(DW);
  localparam logic [CW-1:0] LAST = CW'(OVS - 1);
  localparam logic [CW-1:0] MID  = CW'(OVS / 2 - 1);
  localparam logic [BW-1:0] BLAST = BW'(DW - 1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} st_t;
  st_t st;

  logic [CW-1:0] tcnt;
  logic [BW-1:0] bcnt;
  logic [DW-1:0] shreg;
  logic          pbit;
  logic          unread;

  wire par_on = (par_cfg == 2'b01) || (par_cfg == 2'b10);
  wire bit_pt = baud_tick && (tcnt == LAST);
  wire pe_now = par_on && ((^shreg ^ pbit) != (par_cfg == 2'b10));
  wire fe_now = !rx;
  wire blocked = fifo_mode ? fifo_full : (unread && !hold_rd);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      tcnt       <= '0;
      bcnt       <= '0;
      shreg      <= '0;
      pbit       <= 1'b0;
      unread     <= 1'b0;
      hold_data  <= '0;
      fifo_wr    <= 1'b0;
      fifo_wdata <= '0;
      rx_end     <= 1'b0;
      rx_err     <= 1'b0;
      st_pe      <= 1'b0;
      st_fe      <= 1'b0;
      st_ovr     <= 1'b0;
    end else begin
      rx_end  <= 1'b0;
      rx_err  <= 1'b0;
      fifo_wr <= 1'b0;
      if (hold_rd) unread <= 1'b0;
      if (!rx_en) begin
        st     <= S_IDLE;
        tcnt   <= '0;
        bcnt   <= '0;
        st_pe  <= 1'b0;
        st_fe  <= 1'b0;
        st_ovr <= 1'b0;
      end else begin
        case (st)
          S_IDLE: if (baud_tick && !rx) begin
            st   <= S_START;
            tcnt <= '0;
          end
          S_START: if (baud_tick) begin
            if (tcnt == MID) begin
              tcnt <= '0;
              bcnt <= '0;
              st   <= rx ? S_IDLE : S_DATA;
            end else tcnt <= tcnt + 1'b1;
          end
          S_DATA: if (bit_pt) begin
            tcnt  <= '0;
            shreg <= {rx, shreg[DW-1:1]};
            if (bcnt == BLAST) begin
              bcnt <= '0;
              st   <= par_on ? S_PAR : S_STOP;
            end else bcnt <= bcnt + 1'b1;
          end else if (baud_tick) tcnt <= tcnt + 1'b1;
          S_PAR: if (bit_pt) begin
            tcnt <= '0;
            pbit <= rx;
            st   <= S_STOP;
          end else if (baud_tick) tcnt <= tcnt + 1'b1;
          S_STOP: if (bit_pt) begin
            tcnt  <= '0;
            st    <= S_IDLE;
            st_pe <= st_pe | pe_now;
            st_fe <= st_fe | fe_now;
            if (blocked) begin
              st_ovr <= 1'b1;
              rx_err <= 1'b1;
            end else begin
              if (fifo_mode) begin
                fifo_wr    <= 1'b1;
                fifo_wdata <= {fe_now, pe_now, shreg};
              end else begin
                hold_data <= shreg;
                unread    <= 1'b1;
              end
              rx_err <= pe_now | fe_now;
              rx_end <= !(pe_now | fe_now);
            end
          end else if (baud_tick) tcnt <= tcnt + 1'b1;
          default: st <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/uart_rx_gate_chk.sv
module uart_rx_gate_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rx_en,
  input logic          fifo_mode,
  input logic [DW-1:0] hold_data,
  input logic          fifo_wr,
  input logic          rx_end,
  input logic          rx_err,
  input logic          st_pe,
  input logic          st_fe,
  input logic          st_ovr
);
  AST_HOLD_ONLY_ON_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(hold_data) |-> (rx_end || rx_err)); // R1
  AST_PULSE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_end && rx_err)); // R3
  AST_SILENT_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rx_en) |-> (!rx_end && !rx_err)); // R5
  AST_STATUS_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rx_en) |-> !(st_pe || st_fe || st_ovr)); // R4
  AST_WR_FIFO_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_wr |-> ($past(fifo_mode) && (rx_end != rx_err))); // R9
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st_ovr) && $past(rx_en)) |-> st_ovr); // R2
endmodule

bind uart_rx_gate uart_rx_gate_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .fifo_mode(fifo_mode),
  .hold_data(hold_data), .fifo_wr(fifo_wr), .rx_end(rx_end), .rx_err(rx_err),
  .st_pe(st_pe), .st_fe(st_fe), .st_ovr(st_ovr)
);

// File: tb/uart_rx_gate_bench.sv
module uart_rx_gate_bench;
  localparam int CLK_PERIOD = 10;
  localparam int OVS = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic baud_tick = 1'b1, rx = 1'b1, rx_en = 1'b1, fifo_mode = 1'b0;
  logic [1:0] par_cfg = 2'b00;
  logic hold_rd = 1'b0, fifo_full = 1'b0;
  logic [7:0] hold_data;
  logic fifo_wr;
  logic [9:0] fifo_wdata;
  logic rx_end, rx_err, st_pe, st_fe, st_ovr;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_rx_gate u_uart_rx_gate (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .rx(rx), .rx_en(rx_en),
    .fifo_mode(fifo_mode), .par_cfg(par_cfg), .hold_rd(hold_rd), .fifo_full(fifo_full),
    .hold_data(hold_data), .fifo_wr(fifo_wr), .fifo_wdata(fifo_wdata),
    .rx_end(rx_end), .rx_err(rx_err), .st_pe(st_pe), .st_fe(st_fe), .st_ovr(st_ovr));

  int n_end = 0, n_err = 0, n_wr = 0;
  logic [9:0] last_w = '0;
  always @(negedge clk) begin
    if (rx_end) n_end++;
    if (rx_err) n_err++;
    if (fifo_wr) begin n_wr++; last_w = fifo_wdata; end
  end

  int vecs = 0, fails = 0;
  bit done = 0;
  logic [7:0] m_hold = '0;
  logic m_unread = 0, m_pe = 0, m_fe = 0, m_ovr = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
    end
  endtask

  function automatic logic par_bit(input logic [7:0] d, input logic [1:0] pc);
    return (pc == 2'b10) ? ~(^d) : (^d);
  endfunction

  function automatic bit par_used(input logic [1:0] pc);
    return pc == 2'b01 || pc == 2'b10;
  endfunction

  task automatic hold_bit(input logic b, input int n);
    rx = b;
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input logic [1:0] pc, input bit bad_par, input bit bad_stop);
    par_cfg = pc;
    hold_bit(1'b0, OVS);
    for (int i = 0; i < 8; i++) hold_bit(d[i], OVS);
    if (par_used(pc)) hold_bit(par_bit(d, pc) ^ bad_par, OVS);
    if (bad_stop) begin hold_bit(1'b0, 10); hold_bit(1'b1, OVS - 10); end
    else hold_bit(1'b1, OVS);
    hold_bit(1'b1, 4);
  endtask

  task automatic do_read();
    hold_rd = 1'b1; @(negedge clk); hold_rd = 1'b0;
    m_unread = 0;
  endtask

  task automatic frame(input logic [7:0] d, input logic [1:0] pc, input bit bp, input bit bs, input string req);
    int e0, r0, w0;
    bit pe, fe, blk;
    e0 = n_end; r0 = n_err; w0 = n_wr;
    pe = par_used(pc) && bp;
    fe = bs;
    blk = fifo_mode ? fifo_full : m_unread;
    send(d, pc, bp, bs);
    m_pe |= pe; m_fe |= fe;
    if (blk) m_ovr = 1;
    else if (!fifo_mode) begin m_hold = d; m_unread = 1; end
    chk(n_end - e0 == ((!blk && !pe && !fe) ? 1 : 0), {req, " end pulse"}, n_end - e0, (!blk && !pe && !fe));
    chk(n_err - r0 == ((blk || pe || fe) ? 1 : 0), {req, " err pulse"}, n_err - r0, (blk || pe || fe));
    chk(hold_data == m_hold, {req, " hold"}, hold_data, m_hold);
    chk(n_wr - w0 == ((fifo_mode && !blk) ? 1 : 0), {req, " R9 write count"}, n_wr - w0, (fifo_mode && !blk));
    if (fifo_mode && !blk) chk(last_w == {fe, pe, d}, {req, " R9 word"}, last_w, {fe, pe, d});
    chk({st_pe, st_fe, st_ovr} == {m_pe, m_fe, m_ovr}, {req, " status"}, {st_pe, st_fe, st_ovr}, {m_pe, m_fe, m_ovr});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    void'($urandom(32'd11));
    repeat (3) @(negedge clk);
    chk({hold_data, fifo_wr, rx_end, rx_err, st_pe, st_fe, st_ovr} == 0, "R12 reset",
        {hold_data, fifo_wr, rx_end, rx_err, st_pe, st_fe, st_ovr}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    frame(8'hA5, 2'b00, 0, 0, "R1 no parity");
    do_read();
    frame(8'h3C, 2'b01, 0, 0, "R7 even");
    do_read();
    frame(8'h81, 2'b10, 0, 0, "R7 odd");
    frame(8'h12, 2'b00, 0, 0, "R2 overrun");
    do_read();
    frame(8'h5A, 2'b01, 1, 0, "R3 bad parity");
    do_read();
    frame(8'hC3, 2'b11, 0, 1, "R11 framing");
    do_read();
    frame(8'h66, 2'b00, 0, 0, "R8 read clears unread");

    begin
      int e0, r0;
      logic [7:0] h0;
      e0 = n_end; r0 = n_err; h0 = hold_data;
      hold_bit(1'b0, 4); hold_bit(1'b1, 40);
      chk(n_end == e0 && n_err == r0 && hold_data == h0, "R6 glitch", n_end - e0 + n_err - r0, 0);

      do_read();
      hold_bit(1'b0, OVS);
      hold_bit(1'b1, OVS); hold_bit(1'b0, OVS); hold_bit(1'b1, 5);
      rx_en = 1'b0;
      hold_bit(1'b1, 3);
      chk({st_pe, st_fe, st_ovr} == 3'b000, "R4 status cleared", {st_pe, st_fe, st_ovr}, 0);
      m_pe = 0; m_fe = 0; m_ovr = 0;

      e0 = n_end; r0 = n_err; h0 = hold_data;
      send(8'hF0, 2'b00, 0, 0);
      chk(n_end == e0 && n_err == r0, "R5 disabled no pulse", n_end - e0 + n_err - r0, 0);
      chk(hold_data == h0, "R4 hold unchanged", hold_data, h0);
      rx_en = 1'b1;
      hold_bit(1'b1, 4);
    end

    fifo_mode = 1'b1;
    frame(8'h9E, 2'b01, 0, 0, "R9 fifo clean");
    frame(8'h47, 2'b10, 1, 1, "R9 fifo error word");
    fifo_full = 1'b1;
    frame(8'h2B, 2'b00, 0, 0, "R10 fifo full");
    fifo_full = 1'b0;
    fifo_mode = 1'b0;
    do_read();

    for (int k = 0; k < 150; k++) begin
      fifo_mode = $urandom % 2;
      fifo_full = fifo_mode && ($urandom % 5 == 0);
      if (!fifo_mode && ($urandom % 3 != 0)) do_read();
      frame($urandom, $urandom % 4, $urandom % 6 == 0, $urandom % 6 == 0, "R1 R3 random");
      if ($urandom % 8 == 0) begin
        rx_en = 1'b0; hold_bit(1'b1, 2); rx_en = 1'b1; hold_bit(1'b1, 2);
        m_pe = 0; m_fe = 0; m_ovr = 0;
      end
    end
    finish_run();
  end
endmodule